// File: doc/BRIEF.md
# Composite-Field AES Byte Substitution

This block produces the AES forward S-box value of one byte per clock without a 256-entry table. The byte is first mapped by a linear change of basis into a tower field GF((2^4)^2), where its multiplicative inverse is found with a handful of 4-bit multiplies, squares and one 4-bit inversion. The result is mapped back to the standard GF(2^8) basis, taken modulo x^8 + x^4 + x^3 + x + 1, and then goes through the AES affine step. The basis-change matrices and the tower constant are derived by constant functions at elaboration, so no hand-entered matrix exists in the source.

The parameter `STAGES` selects 0, 2 or 3 register cuts. With 0 the block is purely combinational. With 2 there is one cut after the norm computation and one at the output. With 3 there is an extra cut after the 4-bit inversion. A valid bit runs alongside the data through the same cuts. The block accepts a new byte on every clock.

Top module: `aes_cf_sbox`

## Requirements
- R1: When a byte x is presented with `in_valid` high, the block later presents `out_byte` equal to A(x^-1). Here x^-1 is the inverse modulo x^8+x^4+x^3+x+1, and A flips output bit i to b[i]^b[(i+4)%8]^b[(i+5)%8]^b[(i+6)%8]^b[(i+7)%8]^c[i] with c = 0x63. This holds for all 256 byte values.
- R2: Input 0x00 is treated as having inverse 0x00, so its result is 0x63.
- R3: The result of an input accepted in cycle k appears in cycle k+STAGES, where STAGES is 0, 2 or 3. With 0 it appears in the same cycle.
- R4: `out_valid` equals `in_valid` delayed by STAGES cycles. While reset is asserted and in the first STAGES cycles after its release, `out_valid` is 0.
- R5: Inputs on consecutive cycles give results on consecutive cycles, in the same order, with no bubble.
- R6: With STAGES above 0, `out_byte` keeps its last valid result in every cycle where `out_valid` is low. Pipeline data registers load only when the valid beside them is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid | input | 1 | The input byte is meaningful this cycle |
| in_byte | input | 8 | Byte to substitute |
| out_valid | output | 1 | `out_byte` carries a new result |
| out_byte | output | 8 | Substituted byte |

## Verification
The bench runs three copies (0, 2 and 3 stages) side by side. It compares them with a reference that finds the inverse by exhaustive search and applies the affine step bit by bit. An error in a basis-change matrix or the tower constant would corrupt most of the 256 outputs. A missing zero special case would give something other than 0x63 for 0x00. The sweep feeds all bytes back to back, so a wrong cut count shifts every result by a cycle and a stalled register creates a bubble. Gaps in the random traffic show whether a data register loads without a valid and so breaks the hold of the last result.

// File: rtl/aes_cf_pkg.sv
`timescale 1ns/1ps
package aes_cf_pkg;

  localparam int BYTE_W = 8;
  localparam int NIB_W  = 4;
  localparam logic [BYTE_W-1:0] AFF_C = 8'h63;

  typedef logic [NIB_W-1:0] nib_t;
  typedef logic [BYTE_W-1:0][BYTE_W-1:0] bmat_t;

  // Tower element: hi*y + lo, with y^2 = y + LAMBDA
  typedef struct packed {
    nib_t hi;
    nib_t lo;
  } cf_elem_t;

  // GF(2^4) product, field polynomial x^4 + x + 1
  function automatic nib_t gf16_mul_f(nib_t a, nib_t b);
    nib_t acc;
    nib_t sh;
    acc = '0;
    sh  = a;
    for (int i = 0; i < NIB_W; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = {sh[2:0], 1'b0} ^ (sh[3] ? 4'b0011 : 4'b0000);
    end
    return acc;
  endfunction

  // Squaring is linear: x^4 -> x+1, x^6 -> x^3+x^2
  function automatic nib_t gf16_sq_f(nib_t a);
    return {a[3], a[1] ^ a[3], a[2], a[0] ^ a[2]};
  endfunction

  // Smallest constant making y^2 + y + c irreducible over GF(2^4)
  function automatic nib_t find_lambda_f();
    nib_t res;
    bit   got;
    bit   ok;
    res = '0;
    got = 1'b0;
    for (int c = 1; c < 16; c++) begin
      ok = 1'b1;
      for (int t = 0; t < 16; t++) begin
        if ((gf16_sq_f(nib_t'(t)) ^ nib_t'(t)) == nib_t'(c)) ok = 1'b0;
      end
      if (ok && !got) begin
        res = nib_t'(c);
        got = 1'b1;
      end
    end
    return res;
  endfunction

  localparam nib_t LAMBDA = find_lambda_f();

  function automatic cf_elem_t cf_mul_f(cf_elem_t a, cf_elem_t b);
    cf_elem_t r;
    nib_t     hh;
    hh   = gf16_mul_f(a.hi, b.hi);
    r.hi = hh ^ gf16_mul_f(a.hi, b.lo) ^ gf16_mul_f(a.lo, b.hi);
    r.lo = gf16_mul_f(hh, LAMBDA) ^ gf16_mul_f(a.lo, b.lo);
    return r;
  endfunction

  // A tower element that is a root of x^8 + x^4 + x^3 + x + 1
  function automatic cf_elem_t find_root_f();
    cf_elem_t res;
    cf_elem_t pw;
    cf_elem_t cand;
    logic [BYTE_W-1:0] sum;
    bit got;
    res = '0;
    got = 1'b0;
    for (int r = 2; r < 256; r++) begin
      cand = cf_elem_t'(8'(r));
      pw   = cf_elem_t'(8'h01);
      sum  = 8'h01;
      for (int i = 1; i <= 8; i++) begin
        pw = cf_mul_f(pw, cand);
        if (i == 1 || i == 3 || i == 4 || i == 8) sum = sum ^ pw;
      end
      if (sum == 8'h00 && !got) begin
        res = cand;
        got = 1'b1;
      end
    end
    return res;
  endfunction

  function automatic logic [BYTE_W-1:0] lin_map_f(bmat_t m, logic [BYTE_W-1:0] v);
    logic [BYTE_W-1:0] acc;
    acc = '0;
    for (int i = 0; i < BYTE_W; i++) begin
      if (v[i]) acc = acc ^ m[i];
    end
    return acc;
  endfunction

  // Column i is the image of standard basis bit i
  function automatic bmat_t iso_fwd_f();
    bmat_t    m;
    cf_elem_t root;
    cf_elem_t cur;
    root = find_root_f();
    cur  = cf_elem_t'(8'h01);
    for (int i = 0; i < BYTE_W; i++) begin
      m[i] = cur;
      cur  = cf_mul_f(cur, root);
    end
    return m;
  endfunction

  function automatic bmat_t iso_bwd_f(bmat_t fwd);
    bmat_t m;
    m = '0;
    for (int j = 0; j < BYTE_W; j++) begin
      for (int v = 0; v < 256; v++) begin
        if (lin_map_f(fwd, 8'(v)) == 8'(1 << j)) m[j] = 8'(v);
      end
    end
    return m;
  endfunction

  localparam bmat_t ISO_FWD = iso_fwd_f();
  localparam bmat_t ISO_BWD = iso_bwd_f(ISO_FWD);

endpackage

// File: rtl/sbox_gf16_mul.sv
`timescale 1ns/1ps
module sbox_gf16_mul
  import aes_cf_pkg::*;
(
  input  nib_t a,
  input  nib_t b,
  output nib_t p
);

  nib_t pp [NIB_W];
  nib_t sh [NIB_W];

  // Shifted, reduced copies of a; each selected by one bit of b
  assign sh[0] = a;
  for (genvar i = 1; i < NIB_W; i++) begin : g_shift
    assign sh[i] = {sh[i-1][2:0], 1'b0} ^ (sh[i-1][3] ? 4'b0011 : 4'b0000);
  end

  for (genvar i = 0; i < NIB_W; i++) begin : g_pp
    assign pp[i] = {NIB_W{b[i]}} & sh[i];
  end

  always_comb begin
    p = '0;
    for (int i = 0; i < NIB_W; i++) p = p ^ pp[i];
  end

endmodule

// File: rtl/sbox_gf16_inv.sv
`timescale 1ns/1ps
module sbox_gf16_inv
  import aes_cf_pkg::*;
(
  input  nib_t a,
  output nib_t y
);

  // a^-1 = a^14 = a^2 * a^4 * a^8 ; zero maps to zero
  nib_t a2, a4, a8, a6;

  assign a2 = gf16_sq_f(a);
  assign a4 = gf16_sq_f(a2);
  assign a8 = gf16_sq_f(a4);

  sbox_gf16_mul u_m24 (.a(a2), .b(a4), .p(a6));
  sbox_gf16_mul u_m68 (.a(a6), .b(a8), .p(y));

endmodule

// File: rtl/sbox_lin_map.sv
`timescale 1ns/1ps
module sbox_lin_map
  import aes_cf_pkg::*;
#(
  parameter bmat_t MAT = '0
) (
  input  logic [BYTE_W-1:0] din,
  output logic [BYTE_W-1:0] dout
);

  logic [BYTE_W-1:0] term [BYTE_W];

  for (genvar i = 0; i < BYTE_W; i++) begin : g_col
    assign term[i] = {BYTE_W{din[i]}} & MAT[i];
  end

  always_comb begin
    dout = '0;
    for (int i = 0; i < BYTE_W; i++) dout = dout ^ term[i];
  end

endmodule

// File: rtl/sbox_pipe_reg.sv
`timescale 1ns/1ps
module sbox_pipe_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         vld_i,
  input  logic [W-1:0] dat_i,
  output logic         vld_o,
  output logic [W-1:0] dat_o
);

  logic         vld_d, vld_q;
  logic [W-1:0] dat_d, dat_q;
  logic         armed_q;

  // Next state: data loads only alongside a valid
  always_comb begin
    vld_d = vld_i;
    dat_d = dat_q;
    if (vld_i) dat_d = dat_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q   <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      vld_q   <= vld_d;
      armed_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    dat_q <= dat_d;
  end

  assign vld_o = vld_q;
  assign dat_o = dat_q;

  // R4: valid advances exactly one cut per cycle
  a_r4_valid_step: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q |-> (vld_o == $past(vld_i)));

  // R6: no load without a valid beside it
  a_r6_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && !$past(vld_i)) |-> $stable(dat_o));

endmodule

// File: rtl/aes_cf_sbox.sv
`timescale 1ns/1ps
module aes_cf_sbox
  import aes_cf_pkg::*;
#(
  parameter int STAGES = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_byte,
  output logic              out_valid,
  output logic [BYTE_W-1:0] out_byte
);

  localparam bit CUT_NORM = (STAGES >= 2);
  localparam bit CUT_INV  = (STAGES == 3);
  localparam bit CUT_OUT  = (STAGES >= 2);
  localparam int MID_W    = 3 * NIB_W;

  if (!(STAGES == 0 || STAGES == 2 || STAGES == 3)) begin : g_bad_stages
    $fatal(1, "aes_cf_sbox: STAGES must be 0, 2 or 3");
  end

  // ---- step 1: into the tower field, norm of the element ----
  logic [BYTE_W-1:0] twr_byte;
  cf_elem_t          e0;
  nib_t              hi_sq, lo_sq, hl_prod, hi_sq_lam, norm0;

  sbox_lin_map #(.MAT(ISO_FWD)) u_to_tower (.din(in_byte), .dout(twr_byte));

  assign e0    = cf_elem_t'(twr_byte);
  assign hi_sq = gf16_sq_f(e0.hi);
  assign lo_sq = gf16_sq_f(e0.lo);

  sbox_gf16_mul u_mul_hl  (.a(e0.hi), .b(e0.lo),  .p(hl_prod));
  sbox_gf16_mul u_mul_lam (.a(hi_sq), .b(LAMBDA), .p(hi_sq_lam));

  assign norm0 = hi_sq_lam ^ hl_prod ^ lo_sq;

  // ---- cut after the norm ----
  logic             vld_n;
  logic [MID_W-1:0] cut_n_in, cut_n_out;
  nib_t             hi_n, lo_n, norm_n;

  assign cut_n_in = {e0.hi, e0.lo, norm0};

  if (CUT_NORM) begin : g_cut_norm
    sbox_pipe_reg #(.W(MID_W)) u_cut_norm (
      .clk(clk), .rst_n(rst_n),
      .vld_i(in_valid), .dat_i(cut_n_in),
      .vld_o(vld_n),    .dat_o(cut_n_out));
  end else begin : g_pass_norm
    assign vld_n     = in_valid;
    assign cut_n_out = cut_n_in;
  end

  assign {hi_n, lo_n, norm_n} = cut_n_out;

  // ---- step 2: invert the norm in GF(2^4) ----
  nib_t norm_inv;
  sbox_gf16_inv u_norm_inv (.a(norm_n), .y(norm_inv));

  // ---- cut after the small inversion ----
  logic             vld_i2;
  logic [MID_W-1:0] cut_i_in, cut_i_out;
  nib_t             hi_i, lo_i, ninv_i;

  assign cut_i_in = {hi_n, lo_n, norm_inv};

  if (CUT_INV) begin : g_cut_inv
    sbox_pipe_reg #(.W(MID_W)) u_cut_inv (
      .clk(clk), .rst_n(rst_n),
      .vld_i(vld_n),  .dat_i(cut_i_in),
      .vld_o(vld_i2), .dat_o(cut_i_out));
  end else begin : g_pass_inv
    assign vld_i2    = vld_n;
    assign cut_i_out = cut_i_in;
  end

  assign {hi_i, lo_i, ninv_i} = cut_i_out;

  // ---- step 3: full inverse, back to standard basis, affine ----
  nib_t              hl_sum, inv_hi, inv_lo;
  logic [BYTE_W-1:0] inv_twr, inv_std, aff;

  assign hl_sum = hi_i ^ lo_i;

  sbox_gf16_mul u_mul_ih (.a(hi_i),   .b(ninv_i), .p(inv_hi));
  sbox_gf16_mul u_mul_il (.a(hl_sum), .b(ninv_i), .p(inv_lo));

  assign inv_twr = {inv_hi, inv_lo};

  sbox_lin_map #(.MAT(ISO_BWD)) u_from_tower (.din(inv_twr), .dout(inv_std));

  for (genvar i = 0; i < BYTE_W; i++) begin : g_affine
    assign aff[i] = inv_std[i]
                  ^ inv_std[(i + 4) % BYTE_W]
                  ^ inv_std[(i + 5) % BYTE_W]
                  ^ inv_std[(i + 6) % BYTE_W]
                  ^ inv_std[(i + 7) % BYTE_W]
                  ^ AFF_C[i];
  end

  // ---- output cut ----
  if (CUT_OUT) begin : g_cut_out
    sbox_pipe_reg #(.W(BYTE_W)) u_cut_out (
      .clk(clk), .rst_n(rst_n),
      .vld_i(vld_i2),    .dat_i(aff),
      .vld_o(out_valid), .dat_o(out_byte));
  end else begin : g_pass_out
    assign out_valid = vld_i2;
    assign out_byte  = aff;
  end

  // R1: the basis change is undone exactly by the return matrix
  a_r1_basis_roundtrip: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> (lin_map_f(ISO_BWD, twr_byte) == in_byte));

  // R1: the small inverter really produces the inverse of the norm
  a_r1_norm_inverse: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_n && (norm_n != '0)) |-> (gf16_mul_f(norm_n, norm_inv) == 4'h1));

  // R2/R3: zero input yields 0x63 exactly STAGES cycles later
  if (STAGES == 3) begin : g_zero_chk3
    a_r2_zero_maps: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_byte == '0) |-> ##3 (out_valid && out_byte == AFF_C));
  end else if (STAGES == 2) begin : g_zero_chk2
    a_r2_zero_maps: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_byte == '0) |-> ##2 (out_valid && out_byte == AFF_C));
  end else begin : g_zero_chk0
    a_r2_zero_maps: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_byte == '0) |-> (out_valid && out_byte == AFF_C));
  end

endmodule

// File: tb/aes_cf_sbox_bench.sv
`timescale 1ns/1ps
module aes_cf_sbox_bench;

  localparam int NS      = 720;
  localparam int SWEEP   = 256;
  localparam int MAXCYC  = 200000;

  logic clk;
  logic rst_n;
  logic in_valid;
  logic [7:0] in_byte;

  logic       ov0, ov2, ov3;
  logic [7:0] ob0, ob2, ob3;

  int  n_chk;
  int  n_err;
  bit  done;

  logic       st_v [NS];
  logic [7:0] st_b [NS];
  bit         have_q [3];
  logic [7:0] last_q [3];

  initial clk = 1'b0;
  always #2 clk = ~clk;

  aes_cf_sbox #(.STAGES(0)) u_aes_cf_sbox_s0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
    .out_valid(ov0), .out_byte(ob0));

  aes_cf_sbox #(.STAGES(2)) u_aes_cf_sbox_s2 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
    .out_valid(ov2), .out_byte(ob2));

  aes_cf_sbox u_aes_cf_sbox (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
    .out_valid(ov3), .out_byte(ob3));

  function automatic logic [7:0] ref_mul(logic [7:0] a, logic [7:0] b);
    logic [7:0] acc;
    logic [7:0] sh;
    acc = '0;
    sh  = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = {sh[6:0], 1'b0} ^ (sh[7] ? 8'h1B : 8'h00);
    end
    return acc;
  endfunction

  function automatic logic [7:0] ref_sbox(logic [7:0] x);
    logic [7:0] inv;
    logic [7:0] r;
    inv = 8'h00;
    for (int y = 1; y < 256; y++) begin
      if (x != 8'h00 && ref_mul(x, 8'(y)) == 8'h01) inv = 8'(y);
    end
    for (int i = 0; i < 8; i++) begin
      r[i] = inv[i] ^ inv[(i+4)%8] ^ inv[(i+5)%8] ^ inv[(i+6)%8] ^ inv[(i+7)%8]
           ^ ((8'h63 >> i) & 8'h01) != 8'h00;
    end
    return r;
  endfunction

  task automatic check_dut(input int id, input int lat, input int k,
                           input logic ov, input logic [7:0] ob);
    int         j;
    logic       ev;
    logic [7:0] eb;
    j  = k - lat;
    ev = (j < 0) ? 1'b0 : st_v[j];
    n_chk++;
    if (ov !== ev) begin
      n_err++;
      $display("FAIL %s stages=%0d step=%0d out_valid got %0b exp %0b",
               (j >= 0 && j < SWEEP) ? "R5" : "R4", lat, k, ov, ev);
    end
    if (ev) begin
      eb = ref_sbox(st_b[j]);
      n_chk++;
      if (ob !== eb) begin
        n_err++;
        $display("FAIL %s stages=%0d step=%0d in=%02h out_byte got %02h exp %02h",
                 (st_b[j] == 8'h00) ? "R2" : ((j < SWEEP) ? "R1" : "R3"),
                 lat, k, st_b[j], ob, eb);
      end
      have_q[id] = 1'b1;
      last_q[id] = eb;
    end else if (lat > 0 && have_q[id]) begin
      n_chk++;
      if (ob !== last_q[id]) begin
        n_err++;
        $display("FAIL R6 stages=%0d step=%0d idle out_byte got %02h exp %02h",
                 lat, k, ob, last_q[id]);
      end
    end
  endtask

  // Watchdog: a hang is a failed check
  initial begin
    #(4 * MAXCYC);
    if (!done) begin
      n_err++;
      $display("FAIL R3 watchdog expired got running exp finished");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    int p;
    n_chk    = 0;
    n_err    = 0;
    done     = 1'b0;
    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_byte  = 8'h00;
    void'($urandom(32'd5173));
    for (int i = 0; i < 3; i++) begin
      have_q[i] = 1'b0;
      last_q[i] = 8'h00;
    end

    // R1/R5: full sweep, back to back
    for (int i = 0; i < SWEEP; i++) begin
      st_v[i] = 1'b1;
      st_b[i] = 8'(i);
    end
    p = SWEEP;
    for (int i = 0; i < 4; i++) begin st_v[p] = 1'b0; st_b[p] = 8'hA5; p++; end
    // R2 and isolated corners with gaps (R6)
    st_v[p] = 1'b1; st_b[p] = 8'h00; p++;
    for (int i = 0; i < 3; i++) begin st_v[p] = 1'b0; st_b[p] = 8'h5A; p++; end
    st_v[p] = 1'b1; st_b[p] = 8'hFF; p++;
    st_v[p] = 1'b0; st_b[p] = 8'h00; p++;
    st_v[p] = 1'b1; st_b[p] = 8'h01; p++;
    st_v[p] = 1'b0; st_b[p] = 8'h00; p++;
    // R3/R4/R6: random traffic
    while (p < NS - 5) begin
      st_v[p] = (($urandom % 10) < 7);
      st_b[p] = 8'($urandom);
      p++;
    end
    while (p < NS) begin st_v[p] = 1'b0; st_b[p] = 8'h3C; p++; end

    repeat (3) @(negedge clk);
    // R4: reset state
    n_chk++;
    if (ov0 !== 1'b0 || ov2 !== 1'b0 || ov3 !== 1'b0) begin
      n_err++;
      $display("FAIL R4 reset out_valid got %0b%0b%0b exp 000", ov0, ov2, ov3);
    end
    rst_n = 1'b1;
    @(negedge clk);
    n_chk++;
    if (ov2 !== 1'b0 || ov3 !== 1'b0) begin
      n_err++;
      $display("FAIL R4 after release out_valid got %0b%0b exp 00", ov2, ov3);
    end

    for (int k = 0; k < NS; k++) begin
      @(negedge clk);
      in_valid = st_v[k];
      in_byte  = st_b[k];
      #1;
      check_dut(0, 0, k, ov0, ob0);
      check_dut(1, 2, k, ov2, ob2);
      check_dut(2, 3, k, ov3, ob3);
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule